// File: doc/BRIEF.md
# Host Controller Interrupt Status and Enable Unit

This unit collects interrupt events for a USB-style host controller and turns them into one level-sensitive interrupt line. Every interrupt source has a status bit. A one-cycle event pulse from elsewhere in the controller latches that bit. Software clears a latched bit by writing a one to it. A status bit latches whether or not its source is enabled.

The enable mask has two write addresses. One address sets mask bits and the other clears them, so software never needs a read-modify-write to change one source. Both addresses read back the same mask. The top mask bit is a master gate over all sources.

Software uses a single-cycle 32-bit register port. A write takes effect at the clock edge while `reg_wr` is high. Read data follows `reg_addr` combinationally.

Top module: `irq_status_unit`

## Requirements
- R1: Event input `evt[k]` for k in 0..6 sets status bit k (0 sched overrun, 1 done write-back, 2 frame start, 3 resume, 4 fatal error, 5 frame counter wrap, 6 hub change). `evt[7]` sets status bit 30 (ownership change). The bit becomes visible at address 0 on the edge after the pulse.
- R2: Writing at address 0 clears each status bit written as 1. Bits written as 0 keep their value.
- R3: When an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Writing at address 1 sets each enable bit written as 1. Bits written as 0 keep their value.
- R5: Writing at address 2 clears each enable bit written as 1. Bits written as 0 keep their value.
- R6: Reads at address 1 and at address 2 both return the current enable mask.
- R7: `irq` is high exactly when enable bit 31 (the master enable) is set and at least one status bit is both set and enabled.
- R8: Only bits 0..6 and 30 are implemented in the status register, and only bits 0..6, 30 and 31 in the enable mask. All other bits read 0 and ignore writes. Address 3 reads 0 and ignores writes.
- R9: After reset, all status bits and all enable bits are 0 and `irq` is low.
- R10: A status bit latches on its event even when its enable bit or the master enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe; the write takes effect at this edge |
| reg_addr | input | 2 | Word address: 0 status, 1 enable-set, 2 enable-clear, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt | input | 8 | One-cycle event pulses, one per source |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse arriving on the same edge as a software clear of the same bit. Only in that cycle does the relative priority of set and clear show up. The stimulus table drives `evt[7]` and a clear write to bit 30 in the same vector, and then clears the bit again with no event present. This shows that the bit survived the collision only because of the pulse. The enable and clear addresses are also checked with all-ones data, so that every unimplemented bit is exercised.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int DW = 32,
  parameter int NEV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NEV-1:0] evt,
  output logic          irq
);
  localparam int LOW_SRC = NEV - 1;
  localparam int OWN_BIT = 30;
  localparam int MASTER_BIT = 31;
  localparam logic [DW-1:0] STAT_MASK = (DW'(1) << OWN_BIT) | ((DW'(1) << LOW_SRC) - DW'(1));
  localparam logic [DW-1:0] EN_MASK = STAT_MASK | (DW'(1) << MASTER_BIT);

  logic [DW-1:0] stat_q, en_q, evt_bits, wr_stat, wr_set, wr_clr;

  always_comb begin
    evt_bits = '0;
    evt_bits[LOW_SRC-1:0] = evt[LOW_SRC-1:0];
    evt_bits[OWN_BIT] = evt[NEV-1];
  end

  assign wr_stat = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;
  assign wr_set  = (reg_wr && reg_addr == 2'd1) ? reg_wdata : '0;
  assign wr_clr  = (reg_wr && reg_addr == 2'd2) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= ((stat_q & ~wr_stat) | evt_bits) & STAT_MASK;
      en_q   <= ((en_q | wr_set) & ~wr_clr) & EN_MASK;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = stat_q;
      2'd1,
      2'd2:    reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = en_q[MASTER_BIT] && |(stat_q & en_q & STAT_MASK);
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [7:0]  evt,
  input logic        irq,
  input logic [31:0] stat_q,
  input logic [31:0] en_q
);
  logic [31:0] evb;
  assign evb = {1'b0, evt[7], 23'b0, evt[6:0]};

  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 0) |=> ((stat_q & $past(evb)) == $past(evb)));

  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && evt == 0) |=> ((stat_q & $past(reg_wdata)) == 0));

  a_r4_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=>
      ((en_q & $past(reg_wdata) & 32'hC000_007F) == ($past(reg_wdata) & 32'hC000_007F)));

  a_r5_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2) |=> ((en_q & $past(reg_wdata)) == 0));

  a_r7_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[31] |-> !irq);

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & 32'h3FFF_FF80) == 0) && (reg_addr != 2'd3 || reg_rdata == 0));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (stat_q == 0 && en_q == 0));
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .irq(irq),
  .stat_q(stat_q), .en_q(en_q)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] evt = 0;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .irq(irq));

  // {wr, addr, wdata, evt, exp_status, exp_enable, exp_irq}
  localparam int NV = 17;
  localparam logic [107:0] VEC [0:NV-1] = '{
    {1'b0, 2'd0, 32'h0000_0000, 8'h01, 32'h0000_0001, 32'h0000_0000, 1'b0}, // R1 R10
    {1'b0, 2'd0, 32'h0000_0000, 8'h80, 32'h4000_0001, 32'h0000_0000, 1'b0}, // R1
    {1'b1, 2'd1, 32'h0000_0001, 8'h00, 32'h4000_0001, 32'h0000_0001, 1'b0}, // R4 R7
    {1'b1, 2'd1, 32'h8000_0000, 8'h00, 32'h4000_0001, 32'h8000_0001, 1'b1}, // R7
    {1'b1, 2'd1, 32'h0000_0000, 8'h00, 32'h4000_0001, 32'h8000_0001, 1'b1}, // R4
    {1'b1, 2'd0, 32'h0000_0001, 8'h00, 32'h4000_0000, 32'h8000_0001, 1'b0}, // R2
    {1'b1, 2'd1, 32'h4000_0000, 8'h00, 32'h4000_0000, 32'hC000_0001, 1'b1}, // R7
    {1'b1, 2'd2, 32'h0000_0000, 8'h00, 32'h4000_0000, 32'hC000_0001, 1'b1}, // R5
    {1'b1, 2'd2, 32'h8000_0000, 8'h00, 32'h4000_0000, 32'h4000_0001, 1'b0}, // R5 R7
    {1'b1, 2'd0, 32'h0000_0000, 8'h00, 32'h4000_0000, 32'h4000_0001, 1'b0}, // R2
    {1'b1, 2'd0, 32'h4000_0000, 8'h80, 32'h4000_0000, 32'h4000_0001, 1'b0}, // R3
    {1'b1, 2'd0, 32'h4000_0000, 8'h00, 32'h0000_0000, 32'h4000_0001, 1'b0}, // R2
    {1'b0, 2'd0, 32'h0000_0000, 8'h7E, 32'h0000_007E, 32'h4000_0001, 1'b0}, // R1 R10
    {1'b1, 2'd1, 32'hFFFF_FFFF, 8'h00, 32'h0000_007E, 32'hC000_007F, 1'b1}, // R8
    {1'b1, 2'd0, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 32'hC000_007F, 1'b0}, // R8
    {1'b1, 2'd3, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 32'hC000_007F, 1'b0}, // R8
    {1'b1, 2'd2, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0}  // R5
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic wr, logic [1:0] a, logic [31:0] d, logic [7:0] e);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt = e;
    @(negedge clk);
    reg_wr = 0; evt = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic check_state(string req, logic [31:0] es, logic [31:0] ee, logic ei);
    logic [31:0] v;
    rd(2'd0, v); chk({req, " status"}, v, es);
    rd(2'd1, v); chk({req, " enable@1"}, v, ee);
    rd(2'd2, v); chk({"R6 ", req, " enable@2"}, v, ee);
    chk({"R7 ", req, " irq"}, {31'b0, irq}, {31'b0, ei});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_state("R9 reset", 32'h0, 32'h0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      logic [107:0] w;
      w = VEC[i];
      apply(w[107], w[106:105], w[104:73], w[72:65]);
      check_state($sformatf("vec%0d", i), w[64:33], w[32:1], w[0]);
    end
    rd(2'd3, v); chk("R8 addr3 read", v, 32'h0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] exp;
      exp = (k == 7) ? 32'h4000_0000 : (32'h1 << k);
      apply(1'b0, 2'd0, 32'h0, 8'(1 << k));
      rd(2'd0, v); chk($sformatf("R1 evt%0d", k), v, exp);
      apply(1'b1, 2'd0, 32'hFFFF_FFFF, 8'h0);
    end
    apply(1'b1, 2'd1, 32'hFFFF_FFFF, 8'h00);
    apply(1'b0, 2'd0, 32'h0, 8'h10);
    chk("R7 all on", {31'b0, irq}, 32'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check_state("R9 midrun reset", 32'h0, 32'h0, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule